// File: doc/BRIEF.md
# Thread-Local Bump-Pointer Allocator

This execution unit serves the fast path of object allocation for a managed runtime. Each thread owns a reserved slice of memory and allocates from it by advancing a free pointer, so the common case never contends for the shared heap. The pipeline hands the unit two operands, a requested object size in bytes and a thread context pointer, along with a 5-bit opcode and a start strobe. The unit returns either the address of the new object or a failure flag in a result register.

The per-thread region descriptor sits at a fixed byte offset from the thread context. That offset is loaded once into a configuration register and is not fetched from memory on each call. The descriptor is one memory word. Its low half holds the current free pointer and its high half holds the region ceiling. The unit reads this word through a synchronous data-memory port with one cycle of read latency. On success it writes the word back with the free pointer advanced and the ceiling unchanged.

Every accepted request runs the same six states in order:

1. Latch the operands.
2. Form the descriptor address.
3. Qualify the size and read the descriptor.
4. Compute the candidate pointer.
5. Test the remaining space.
6. Commit the result and report completion.

Requests that are too large or that do not fit fail without changing memory. The caller then takes a slow path, which lies outside this unit.

Top module: `tlab_alloc_unit`

## Requirements
- R1: After reset, busy, done, result_fail and result_addr are all 0. No memory read or write occurs while busy is 0.
- R2: A start sampled with opcode equal to OPC_ALLOC (default 5'b01011) while idle raises busy from the next cycle for exactly 6 cycles. done is high only in the 6th of those cycles, and busy is 0 in the cycle after done.
- R3: A start with any other opcode is ignored. A start that arrives while busy is also ignored. Neither one changes busy, memory or the result of the operation in flight.
- R4: The descriptor address is src_ctx plus the value last written through cfg_we/cfg_offset. A valid request performs exactly one read, at that address. The read data carries the free pointer in bits [31:0] and the ceiling in bits [63:32].
- R5: A size of 0, or a size above MAX_OBJ (default 4096), fails. It returns result_addr 0 and result_fail 1, and performs no memory read or write.
- R6: A valid size is rounded up to a multiple of 4 before the space check and before the pointer is advanced.
- R7: A request whose rounded size satisfies free + size <= ceiling succeeds. It returns the old free pointer with result_fail 0 and writes exactly once the word {ceiling, free + rounded size} to the descriptor address. The exact-fit case succeeds.
- R8: When free + rounded size exceeds the ceiling, compared without wraparound, the request fails with result_addr 0 and performs no write.
- R9: result_addr and result_fail hold their values from one completion until the next completion.
- R10: Whenever result_fail is 1, result_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the descriptor offset register |
| cfg_offset | input | 32 | Byte offset from thread context to descriptor |
| start | input | 1 | Request strobe from the pipeline |
| opcode | input | 5 | Operation select; the unit responds to OPC_ALLOC |
| src_size | input | 32 | Requested object size in bytes |
| src_ctx | input | 32 | Thread context pointer |
| busy | output | 1 | High from acceptance until completion |
| done | output | 1 | One-cycle completion pulse |
| result_addr | output | 32 | Allocated address, or 0 on failure |
| result_fail | output | 1 | Allocation failed |
| mem_re | output | 1 | Descriptor read strobe |
| mem_we | output | 1 | Descriptor write strobe |
| mem_addr | output | 32 | Descriptor address |
| mem_wdata | output | 64 | Updated descriptor {ceiling, free} |
| mem_rdata | input | 64 | Descriptor read data, valid one cycle after mem_re |

## Verification
The assertions check, on every cycle, the following properties:
- A failed result always carries address zero.
- The memory port stays silent while idle.
- Each read is a single-cycle strobe.
- A written free pointer keeps the alignment of the old one and never passes the ceiling.
- Results change only at completion.
- done is followed by idle.

Only the bench scenarios can show the arithmetic outcome: which sizes pass the validity window, how rounding interacts with the remaining slack in an exhaustive sweep, the wraparound case near the top of the address space, and that a redirected offset moves the descriptor access. The same holds for the exact six-cycle latency and for the rejection of foreign opcodes and of restarts while busy.

// File: rtl/tlab_pkg.sv
package tlab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOKUP = 3'd1,
    ST_READ   = 3'd2,
    ST_CALC   = 3'd3,
    ST_TEST   = 3'd4,
    ST_UPDATE = 3'd5,
    ST_DONE   = 3'd6
  } tlab_state_e;

endpackage

// File: rtl/tlab_seq.sv
module tlab_seq
  import tlab_pkg::*;
#(
  parameter int OPC_W = 5,
  parameter logic [OPC_W-1:0] OPC_ALLOC = 5'b01011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output logic             accept,
  output tlab_state_e      state,
  output logic             busy,
  output logic             done
);

  assign accept = (state == ST_IDLE) && start && (opcode == OPC_ALLOC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_LOOKUP;
            busy  <= 1'b1;
          end
        end
        ST_LOOKUP: state <= ST_READ;
        ST_READ:   state <= ST_CALC;
        ST_CALC:   state <= ST_TEST;
        ST_TEST:   state <= ST_UPDATE;
        ST_UPDATE: begin
          state <= ST_DONE;
          done  <= 1'b1;
        end
        ST_DONE: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b0;
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b0;
        end
      endcase
    end
  end

  // R2: completion pulse lasts one cycle and returns to idle
  p_done_then_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !done));

  // R2: completion only occurs inside a busy window
  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R3: a new request never disturbs a running sequence
  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/tlab_size_qual.sv
module tlab_size_qual #(
  parameter int AW        = 32,
  parameter int MAX_OBJ   = 4096,
  parameter int ALIGN_LG2 = 2
) (
  input  logic [AW-1:0] size,
  output logic          ok,
  output logic [AW-1:0] rsize
);

  localparam logic [AW-1:0] LIMIT = AW'(MAX_OBJ);

  assign ok = (size != '0) && (size <= LIMIT);

  generate
    if (ALIGN_LG2 == 0) begin : g_no_round
      assign rsize = size;
    end else begin : g_round
      localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN_LG2) - 1);
      logic [AW-1:0] bumped;
      assign bumped = size + LOW_MASK;
      assign rsize  = bumped & ~LOW_MASK;
    end
  endgenerate

endmodule

// File: rtl/tlab_fit.sv
module tlab_fit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] free_ptr,
  input  logic [AW-1:0] rsize,
  input  logic [AW:0]   cand_hold,
  input  logic [AW-1:0] ceil_ptr,
  output logic [AW:0]   cand,
  output logic          fits
);

  assign cand = {1'b0, free_ptr} + {1'b0, rsize};
  assign fits = (cand_hold <= {1'b0, ceil_ptr});

endmodule

// File: rtl/tlab_alloc_unit.sv
module tlab_alloc_unit
  import tlab_pkg::*;
#(
  parameter int AW        = 32,
  parameter int OPC_W     = 5,
  parameter logic [OPC_W-1:0] OPC_ALLOC = 5'b01011,
  parameter int MAX_OBJ   = 4096,
  parameter int ALIGN_LG2 = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_offset,
  input  logic            start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [AW-1:0]   src_size,
  input  logic [AW-1:0]   src_ctx,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   result_addr,
  output logic            result_fail,
  output logic            mem_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [2*AW-1:0] mem_wdata,
  input  logic [2*AW-1:0] mem_rdata
);

  localparam int DW = 2 * AW;

  tlab_state_e   state;
  logic          accept;
  logic [AW-1:0] offset_q;
  logic [AW-1:0] size_q;
  logic [AW-1:0] ctx_q;
  logic [AW-1:0] region_q;
  logic          ok_q;
  logic [AW-1:0] rsize_q;
  logic [AW-1:0] free_q;
  logic [AW-1:0] ceil_q;
  logic [AW:0]   cand_q;
  logic          fits_q;
  logic          size_ok;
  logic [AW-1:0] size_rnd;
  logic [AW:0]   cand_c;
  logic          fits_c;

  tlab_seq #(
    .OPC_W     (OPC_W),
    .OPC_ALLOC (OPC_ALLOC)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (opcode),
    .accept (accept),
    .state  (state),
    .busy   (busy),
    .done   (done)
  );

  tlab_size_qual #(
    .AW        (AW),
    .MAX_OBJ   (MAX_OBJ),
    .ALIGN_LG2 (ALIGN_LG2)
  ) u_size (
    .size  (size_q),
    .ok    (size_ok),
    .rsize (size_rnd)
  );

  tlab_fit #(
    .AW (AW)
  ) u_fit (
    .free_ptr  (mem_rdata[AW-1:0]),
    .rsize     (rsize_q),
    .cand_hold (cand_q),
    .ceil_ptr  (ceil_q),
    .cand      (cand_c),
    .fits      (fits_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q    <= '0;
      size_q      <= '0;
      ctx_q       <= '0;
      region_q    <= '0;
      ok_q        <= 1'b0;
      rsize_q     <= '0;
      free_q      <= '0;
      ceil_q      <= '0;
      cand_q      <= '0;
      fits_q      <= 1'b0;
      result_addr <= '0;
      result_fail <= 1'b0;
    end else begin
      if (cfg_we) begin
        offset_q <= cfg_offset;
      end
      if (accept) begin
        size_q <= src_size;
        ctx_q  <= src_ctx;
      end
      unique case (state)
        ST_LOOKUP: region_q <= ctx_q + offset_q;
        ST_READ: begin
          ok_q    <= size_ok;
          rsize_q <= size_rnd;
        end
        ST_CALC: begin
          free_q <= mem_rdata[AW-1:0];
          ceil_q <= mem_rdata[DW-1:AW];
          cand_q <= cand_c;
        end
        ST_TEST: fits_q <= ok_q && fits_c;
        ST_UPDATE: begin
          result_addr <= fits_q ? free_q : '0;
          result_fail <= !fits_q;
        end
        default: ;
      endcase
    end
  end

  assign mem_re    = (state == ST_READ) && size_ok;
  assign mem_we    = (state == ST_UPDATE) && fits_q;
  assign mem_addr  = region_q;
  assign mem_wdata = {ceil_q, cand_q[AW-1:0]};

  // R10: a failed result carries a null address
  p_fail_null_r10: assert property (@(posedge clk) disable iff (rst)
    result_fail |-> (result_addr == '0));

  // R1: memory port is quiet outside an operation
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_re && !mem_we));

  // R4: one descriptor read per request
  p_single_read_r4: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  // R6: advancing keeps the alignment of the free pointer
  p_write_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[ALIGN_LG2:0] == free_q[ALIGN_LG2:0]) || (ALIGN_LG2 == 0)
               || (mem_wdata[ALIGN_LG2-1:0] == free_q[ALIGN_LG2-1:0]));

  // R7: the written free pointer never passes the ceiling
  p_below_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[AW-1:0] <= mem_wdata[DW-1:AW]));

  // R9: results move only when a sequence commits
  p_results_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_UPDATE) |=> ($stable(result_addr) && $stable(result_fail)));

endmodule

// File: tb/tlab_alloc_unit_bench.sv
`timescale 1ns/1ps
module tlab_alloc_unit_bench;

  localparam logic [4:0] OPC = 5'b01011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_offset = '0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] src_size = '0;
  logic [31:0] src_ctx = '0;
  logic        busy, done, result_fail, mem_re, mem_we;
  logic [31:0] result_addr, mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;

  logic [63:0] mem [16];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] cur_off = '0;

  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  tlab_alloc_unit u_tlab_alloc_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_offset(cfg_offset),
    .start(start), .opcode(opcode), .src_size(src_size), .src_ctx(src_ctx),
    .busy(busy), .done(done), .result_addr(result_addr), .result_fail(result_fail),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata    <= mem[mem_addr[3:0]];
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= mem_addr;
    end
    if (mem_we) begin
      mem[mem_addr[3:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_offset(input logic [31:0] off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_offset = off;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_off = off;
  endtask

  // Full request with timing, result, and memory-effect checks.
  task automatic do_alloc(input logic [31:0] ctx, input logic [31:0] size,
                          input string tag);
    logic [31:0] region;
    logic [63:0] f, c, r, word0, exp_word;
    logic        valid, fits;
    int          rd0, wr0;
    region = ctx + cur_off;
    word0  = mem[region[3:0]];
    f = {32'd0, word0[31:0]};
    c = {32'd0, word0[63:32]};
    valid = (size != 0) && (size <= 32'd4096);
    r = ({32'd0, size} + 64'd3) & ~64'd3;
    fits = valid && ((f + r) <= c);
    exp_word = fits ? {c[31:0], 32'(f + r)} : word0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; opcode = OPC; src_size = size; src_ctx = ctx;
    @(negedge clk);
    start = 1'b0; src_size = '0; src_ctx = '0;
    for (int k = 1; k <= 6; k++) begin
      chk("R2 busy window", {63'd0, busy}, 64'd1);
      chk("R2 done timing", {63'd0, done}, (k == 6) ? 64'd1 : 64'd0);
      if (k < 6) @(negedge clk);
    end
    chk({tag, " addr"}, {32'd0, result_addr}, fits ? f : 64'd0);
    chk({tag, " fail"}, {63'd0, result_fail}, fits ? 64'd0 : 64'd1);
    @(negedge clk);
    chk("R2 idle after done", {62'd0, busy, done}, 64'd0);
    chk(valid ? "R4 read count" : "R5 read count", 64'(rd_cnt - rd0), valid ? 64'd1 : 64'd0);
    chk(fits ? "R7 write count" : "R8 write count", 64'(wr_cnt - wr0), fits ? 64'd1 : 64'd0);
    chk({tag, " descriptor"}, mem[region[3:0]], exp_word);
    if (valid) chk("R4 read address", {32'd0, last_rd_addr}, {32'd0, region});
  endtask

  task automatic set_region(input logic [3:0] idx, input logic [31:0] f, input logic [31:0] c);
    mem[idx] = {c, f};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy/done", {62'd0, busy, done}, 64'd0);
    chk("R1 result", {31'd0, result_fail, result_addr}, 64'd0);
    chk("R1 no access", 64'(rd_cnt + wr_cnt), 64'd0);

    set_offset(32'h0000_0008);

    // R5/R6 size sweep in a roomy region
    for (int s = 0; s <= 20; s++) begin
      set_region(4'd9, 32'h0000_2000, 32'h0001_0000);
      do_alloc(32'h1, 32'(s), (s == 0) ? "R5" : "R6");
    end
    for (int s = 4090; s <= 4100; s++) begin
      set_region(4'd9, 32'h0000_2000, 32'h0001_0000);
      do_alloc(32'h1, 32'(s), (s > 4096) ? "R5" : "R7");
    end
    set_region(4'd9, 32'h0000_2000, 32'h0001_0000);
    do_alloc(32'h1, 32'hFFFF_FFFF, "R5");

    // R7/R8 exhaustive slack versus size sweep, including exact fits
    for (int sl = 0; sl <= 12; sl++) begin
      for (int s = 1; s <= 12; s++) begin
        set_region(4'd10, 32'h0000_1000, 32'h0000_1000 + 32'(sl));
        do_alloc(32'h2, 32'(s), "R8");
      end
    end

    // R8 no wraparound near the top of the address space
    set_region(4'd10, 32'hFFFF_FFF0, 32'hFFFF_FFFC);
    do_alloc(32'h2, 32'd16, "R8");
    set_region(4'd10, 32'hFFFF_FFF0, 32'hFFFF_FFFC);
    do_alloc(32'h2, 32'd12, "R7");

    // R7 consecutive allocations advance the pointer
    set_region(4'd11, 32'h0000_0400, 32'h0000_0440);
    for (int n = 0; n < 6; n++) do_alloc(32'h3, 32'd13, "R7");

    // R4 offset register redirects the descriptor
    set_offset(32'h0000_0004);
    set_region(4'd7, 32'h0000_3000, 32'h0000_3100);
    set_region(4'd11, 32'h0000_0500, 32'h0000_0600);
    do_alloc(32'h3, 32'd8, "R4");
    chk("R4 old slot untouched", mem[4'd11], {32'h0000_0600, 32'h0000_0500});

    // R3 foreign opcode ignored; R9 result holds
    begin
      logic [31:0] a0;
      logic        f0;
      int          rd0, wr0;
      a0 = result_addr; f0 = result_fail; rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      start = 1'b1; opcode = 5'b01010; src_size = 32'd4; src_ctx = 32'h3;
      @(negedge clk);
      start = 1'b0;
      chk("R3 bad opcode busy", {63'd0, busy}, 64'd0);
      repeat (7) @(negedge clk);
      chk("R3 bad opcode no access", 64'((rd_cnt - rd0) + (wr_cnt - wr0)), 64'd0);
      chk("R9 addr held", {32'd0, result_addr}, {32'd0, a0});
      chk("R9 fail held", {63'd0, result_fail}, {63'd0, f0});
    end

    // R3 restart while busy ignored
    begin
      int rd0, wr0;
      set_region(4'd7, 32'h0000_3000, 32'h0000_3100);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      start = 1'b1; opcode = OPC; src_size = 32'd20; src_ctx = 32'h3;
      @(negedge clk);
      src_size = 32'd64; src_ctx = 32'h6;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 done of first", {63'd0, done}, 64'd1);
      chk("R3 first result", {32'd0, result_addr}, 64'h3000);
      @(negedge clk);
      chk("R3 not extended", {62'd0, busy, done}, 64'd0);
      repeat (8) @(negedge clk);
      chk("R3 single op reads", 64'(rd_cnt - rd0), 64'd1);
      chk("R3 single op writes", 64'(wr_cnt - wr0), 64'd1);
      chk("R3 descriptor", mem[4'd7], {32'h0000_3100, 32'h0000_3014});
      chk("R10 fail implies null", {63'd0, (result_fail && result_addr != 0)}, 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule